// File: doc/BRIEF.md
# Adaptive Circuit Channel Setup Controller

This block runs one channel request at a time inside a switch of a mesh that uses circuit switching. When a request arrives with a destination coordinate pair, it works out the one or two shortest-path output directions toward that destination. It claims a lane in every direction that has one free and forwards the request on each claimed lane. It then waits until all of them have answered.

From the answers it either returns a deny upstream and gives every claimed lane back, or it settles on one path and returns a grant. It also frees the losing lane. The chosen path is the one whose port has fewer busy lanes. When the busy counts are equal, the port with the lower identifier wins. The kept lane stays reserved until the requester reports that no more data follows, and then it is released.

The controller is a six-state machine:
- **IDLE** accepts a request and moves to **ROUTE**.
- **ROUTE** claims lanes. It goes to **WAIT_REPLY** if it claimed any, and otherwise back to **IDLE**.
- **WAIT_REPLY** moves to **RESOLVE** once every reply is in.
- **RESOLVE** goes to **TRANSFER** when at least one direction granted, and otherwise back to **IDLE**.
- **TRANSFER** moves to **RELEASE** when the requester signals the end of data.
- **RELEASE** always returns to **IDLE**.

Top module: `chan_setup_ctrl`

## Requirements
- R1: Direction port IDs and bit positions in every per-direction vector are east=0, west=1, north=2, south=3.
    - The X-axis direction toward the destination is candidate C0: east if dst_x > MY_X, west if dst_x < MY_X.
    - The Y-axis direction is C1: north if dst_y > MY_Y, south if dst_y < MY_Y.
    - When only one axis differs, that axis alone is C0.
    - When the destination equals the switch's own coordinates, there is no candidate.
- R2: A request is sampled only in IDLE. In the following cycle (ROUTE), claim_o pulses for exactly the candidate directions whose lane_free_i bit is set.
- R3: If no candidate has a free lane, up_dny_o is high in that same ROUTE cycle. Nothing is forwarded and the machine returns to IDLE.
- R4: In WAIT_REPLY, down_req_o is high on each claimed direction that has not yet answered. Replies may arrive in different cycles. Neither up_gnt_o nor up_dny_o rises before every claimed direction has answered.
- R5: If every forwarded request is denied, the RESOLVE cycle drives up_dny_o and releases every claimed lane on rel_o.
- R6: If both candidates grant, C0 wins when busy_i of its port is smaller. On equal counts, the lower port ID wins. Otherwise C1 wins. In the RESOLVE cycle, up_gnt_o is high and rel_o frees the loser.
- R7: If exactly one candidate grants, it wins. In the RESOLVE cycle, up_gnt_o is high and rel_o frees any lane claimed for the other candidate.
- R8: In TRANSFER, chan_active_o is high and sel_dir_o holds the winning direction until xfer_done_i. The next cycle (RELEASE) drives rel_o for the winning direction, and the machine then returns to IDLE.
- R9: req_i outside IDLE has no effect: no claim, no state change, and no request taken after the channel ends.
- R10: Over every transaction, each direction sees as many rel_o pulses as claim_o pulses, so no lane is leaked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Channel request from upstream |
| dst_x_i | input | COORD_W | Destination X coordinate |
| dst_y_i | input | COORD_W | Destination Y coordinate |
| lane_free_i | input | 4 | Per-direction: port has a free lane |
| busy_i | input | 4*CNT_W | Per-direction busy-lane count |
| down_gnt_i | input | 4 | Per-direction grant reply |
| down_dny_i | input | 4 | Per-direction deny reply |
| xfer_done_i | input | 1 | Requester signals end of data |
| claim_o | output | 4 | Per-direction lane claim pulse |
| rel_o | output | 4 | Per-direction lane release pulse |
| down_req_o | output | 4 | Per-direction forwarded request |
| up_gnt_o | output | 1 | Grant pulse to requester |
| up_dny_o | output | 1 | Deny pulse to requester |
| chan_active_o | output | 1 | Channel in data transfer |
| sel_dir_o | output | 2 | Winning direction during transfer |

## Verification
The bench sweeps every destination on a 5x5 grid around a switch at (2,2), so that same-axis, diagonal and self-addressed requests all occur. It crosses each destination with all sixteen free-lane masks and all four grant patterns on the two candidates. The free-lane masks separate claiming only free candidates from immediate denial. The grant patterns separate all-deny, single-grant on either candidate and double-grant resolution. Busy counts vary per direction and are sometimes set equal, which tells the busy-count comparison apart from the port-ID tie-break. Replies are sometimes split over two cycles to show that no upstream answer comes early.

// File: rtl/chan_setup_pkg.sv
package chan_setup_pkg;
    localparam int NDIR  = 4;
    localparam int DIR_W = $clog2(NDIR);

    typedef enum logic [1:0] {
        DIR_E = 2'd0,
        DIR_W_ = 2'd1,
        DIR_N = 2'd2,
        DIR_S = 2'd3
    } dir_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ROUTE,
        S_WAIT_REPLY,
        S_RESOLVE,
        S_TRANSFER,
        S_RELEASE
    } state_t;

    function automatic logic [NDIR-1:0] dir_bit(input dir_t d);
        return NDIR'(1) << d;
    endfunction
endpackage

// File: rtl/chsc_route_calc.sv
module chsc_route_calc
    import chan_setup_pkg::*;
#(
    parameter int COORD_W = 3,
    parameter int MY_X    = 2,
    parameter int MY_Y    = 2
) (
    input  logic [COORD_W-1:0] dst_x_i,
    input  logic [COORD_W-1:0] dst_y_i,
    output dir_t               c0_o,
    output dir_t               c1_o,
    output logic               c0_v_o,
    output logic               c1_v_o,
    output logic [NDIR-1:0]    cand_o
);
    localparam logic [COORD_W-1:0] HOME_X = COORD_W'(MY_X);
    localparam logic [COORD_W-1:0] HOME_Y = COORD_W'(MY_Y);

    dir_t x_dir, y_dir;
    logic x_off, y_off;

    always_comb begin
        x_off = (dst_x_i != HOME_X);
        y_off = (dst_y_i != HOME_Y);
        x_dir = (dst_x_i > HOME_X) ? DIR_E : DIR_W_;
        y_dir = (dst_y_i > HOME_Y) ? DIR_N : DIR_S;
        if (x_off) begin
            c0_o   = x_dir;
            c0_v_o = 1'b1;
            c1_o   = y_dir;
            c1_v_o = y_off;
        end else begin
            c0_o   = y_dir;
            c0_v_o = y_off;
            c1_o   = DIR_E;
            c1_v_o = 1'b0;
        end
        cand_o = (c0_v_o ? dir_bit(c0_o) : '0) | (c1_v_o ? dir_bit(c1_o) : '0);
    end
endmodule

// File: rtl/chsc_reply_track.sv
module chsc_reply_track
    import chan_setup_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            enable_i,
    input  logic [NDIR-1:0] mask_i,
    input  logic [NDIR-1:0] gnt_i,
    input  logic [NDIR-1:0] dny_i,
    output logic [NDIR-1:0] pend_o,
    output logic [NDIR-1:0] gnt_q_o,
    output logic            all_in_o
);
    logic [NDIR-1:0] ans_q, ans_nxt, gnt_q, gnt_nxt, fresh;

    always_comb begin
        fresh    = (gnt_i | dny_i) & mask_i & ~ans_q;
        ans_nxt  = ans_q | fresh;
        gnt_nxt  = gnt_q | (gnt_i & fresh);
        all_in_o = enable_i && (ans_nxt == mask_i);
        pend_o   = mask_i & ~ans_q;
        gnt_q_o  = gnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ans_q <= '0;
            gnt_q <= '0;
        end else if (clear_i) begin
            ans_q <= '0;
            gnt_q <= '0;
        end else if (enable_i) begin
            ans_q <= ans_nxt;
            gnt_q <= gnt_nxt;
        end
    end
endmodule

// File: rtl/chsc_path_select.sv
module chsc_path_select
    import chan_setup_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  dir_t                 c0_i,
    input  dir_t                 c1_i,
    input  logic                 c0_v_i,
    input  logic                 c1_v_i,
    input  logic [NDIR-1:0]      gnt_i,
    input  logic [NDIR*CNT_W-1:0] busy_i,
    output logic [NDIR-1:0]      win_o,
    output logic                 any_o
);
    logic g0, g1;
    logic [CNT_W-1:0] b0, b1;
    logic pick_c0;

    always_comb begin
        g0 = c0_v_i && gnt_i[c0_i];
        g1 = c1_v_i && gnt_i[c1_i];
        b0 = busy_i[int'(c0_i)*CNT_W +: CNT_W];
        b1 = busy_i[int'(c1_i)*CNT_W +: CNT_W];
        if (b0 < b1)       pick_c0 = 1'b1;
        else if (b0 == b1) pick_c0 = (c0_i < c1_i);
        else               pick_c0 = 1'b0;
        any_o = g0 || g1;
        if (g0 && g1)  win_o = pick_c0 ? dir_bit(c0_i) : dir_bit(c1_i);
        else if (g0)   win_o = dir_bit(c0_i);
        else if (g1)   win_o = dir_bit(c1_i);
        else           win_o = '0;
    end
endmodule

// File: rtl/chan_setup_ctrl.sv
module chan_setup_ctrl
    import chan_setup_pkg::*;
#(
    parameter int COORD_W = 3,
    parameter int CNT_W   = 3,
    parameter int MY_X    = 2,
    parameter int MY_Y    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_i,
    input  logic [COORD_W-1:0]    dst_x_i,
    input  logic [COORD_W-1:0]    dst_y_i,
    input  logic [NDIR-1:0]       lane_free_i,
    input  logic [NDIR*CNT_W-1:0] busy_i,
    input  logic [NDIR-1:0]       down_gnt_i,
    input  logic [NDIR-1:0]       down_dny_i,
    input  logic                  xfer_done_i,
    output logic [NDIR-1:0]       claim_o,
    output logic [NDIR-1:0]       rel_o,
    output logic [NDIR-1:0]       down_req_o,
    output logic                  up_gnt_o,
    output logic                  up_dny_o,
    output logic                  chan_active_o,
    output logic [DIR_W-1:0]      sel_dir_o
);
    state_t state_q, state_nxt;
    logic [COORD_W-1:0] dst_x_q, dst_y_q;
    logic [NDIR-1:0] held_q, held_nxt;

    dir_t c0, c1;
    logic c0_v, c1_v;
    logic [NDIR-1:0] cand, pend, gnt_q, win;
    logic all_in, any_gnt;

    chsc_route_calc #(.COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)) route_i (
        .dst_x_i(dst_x_q), .dst_y_i(dst_y_q),
        .c0_o(c0), .c1_o(c1), .c0_v_o(c0_v), .c1_v_o(c1_v), .cand_o(cand)
    );

    chsc_reply_track reply_i (
        .clk(clk), .rst_n(rst_n),
        .clear_i(state_q == S_ROUTE), .enable_i(state_q == S_WAIT_REPLY),
        .mask_i(held_q), .gnt_i(down_gnt_i), .dny_i(down_dny_i),
        .pend_o(pend), .gnt_q_o(gnt_q), .all_in_o(all_in)
    );

    chsc_path_select #(.CNT_W(CNT_W)) select_i (
        .c0_i(c0), .c1_i(c1), .c0_v_i(c0_v), .c1_v_i(c1_v),
        .gnt_i(gnt_q), .busy_i(busy_i), .win_o(win), .any_o(any_gnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            held_q  <= '0;
            dst_x_q <= '0;
            dst_y_q <= '0;
        end else begin
            state_q <= state_nxt;
            held_q  <= held_nxt;
            if (state_q == S_IDLE && req_i) begin
                dst_x_q <= dst_x_i;
                dst_y_q <= dst_y_i;
            end
        end
    end

    always_comb begin
        state_nxt     = state_q;
        held_nxt      = held_q;
        claim_o       = '0;
        rel_o         = '0;
        down_req_o    = '0;
        up_gnt_o      = 1'b0;
        up_dny_o      = 1'b0;
        chan_active_o = 1'b0;
        sel_dir_o     = '0;
        unique case (state_q)
            S_IDLE: begin
                if (req_i) state_nxt = S_ROUTE;
            end
            S_ROUTE: begin
                claim_o  = cand & lane_free_i;
                held_nxt = claim_o;
                if (claim_o == '0) begin
                    up_dny_o  = 1'b1;
                    state_nxt = S_IDLE;
                end else begin
                    state_nxt = S_WAIT_REPLY;
                end
            end
            S_WAIT_REPLY: begin
                down_req_o = pend;
                if (all_in) state_nxt = S_RESOLVE;
            end
            S_RESOLVE: begin
                if (any_gnt) begin
                    up_gnt_o  = 1'b1;
                    rel_o     = held_q & ~win;
                    held_nxt  = win;
                    state_nxt = S_TRANSFER;
                end else begin
                    up_dny_o  = 1'b1;
                    rel_o     = held_q;
                    held_nxt  = '0;
                    state_nxt = S_IDLE;
                end
            end
            S_TRANSFER: begin
                chan_active_o = 1'b1;
                for (int d = 0; d < NDIR; d++)
                    if (held_q[d]) sel_dir_o = DIR_W'(d);
                if (xfer_done_i) state_nxt = S_RELEASE;
            end
            S_RELEASE: begin
                rel_o     = held_q;
                held_nxt  = '0;
                state_nxt = S_IDLE;
            end
            default: state_nxt = S_IDLE;
        endcase
    end

    // Candidate set from the route calculator: at most two, never opposite.
    assert_cand_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cand) <= 2) && !(cand[DIR_E] && cand[DIR_W_]) && !(cand[DIR_N] && cand[DIR_S]));

    // Lanes are claimed only in the cycle after a sampled request.
    assert_claim_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_o != '0) |-> $past(req_i));

    // An upstream grant only follows a completed reply collection.
    assert_grant_after_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        up_gnt_o |-> ($past(state_q) == S_WAIT_REPLY));

    // Grant and deny never together.
    assert_gnt_dny_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_gnt_o && up_dny_o));

    // The selected path is a single granted direction.
    assert_win_granted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RESOLVE) |-> (((win & ~gnt_q) == '0) && $onehot0(win)));

    // Transfer holds its direction until the end of data.
    assert_hold_transfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TRANSFER && !xfer_done_i) |=> (chan_active_o && $stable(sel_dir_o)));

    // Only owned lanes are ever released.
    assert_release_owned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((rel_o & ~held_q) == '0));
endmodule

// File: tb/chan_setup_ctrl_tb_top.sv
module chan_setup_ctrl_tb_top;
    localparam int CW = 3, BW = 3, MX = 2, MY = 2, ND = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic            req_i = 1'b0;
    logic [CW-1:0]   dst_x_i = '0, dst_y_i = '0;
    logic [ND-1:0]   lane_free_i = '0;
    logic [ND*BW-1:0] busy_i = '0;
    logic [ND-1:0]   down_gnt_i = '0, down_dny_i = '0;
    logic            xfer_done_i = 1'b0;
    logic [ND-1:0]   claim_o, rel_o, down_req_o;
    logic            up_gnt_o, up_dny_o, chan_active_o;
    logic [1:0]      sel_dir_o;

    chan_setup_ctrl #(.COORD_W(CW), .CNT_W(BW), .MY_X(MX), .MY_Y(MY)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .dst_x_i(dst_x_i), .dst_y_i(dst_y_i),
        .lane_free_i(lane_free_i), .busy_i(busy_i), .down_gnt_i(down_gnt_i),
        .down_dny_i(down_dny_i), .xfer_done_i(xfer_done_i), .claim_o(claim_o),
        .rel_o(rel_o), .down_req_o(down_req_o), .up_gnt_o(up_gnt_o), .up_dny_o(up_dny_o),
        .chan_active_o(chan_active_o), .sel_dir_o(sel_dir_o)
    );

    int checks = 0, errors = 0;
    int res[ND];
    int bv[ND];

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic next_cyc();
        @(negedge clk);
    endtask

    task automatic acct();
        #2;
        for (int d = 0; d < ND; d++) res[d] += int'(claim_o[d]) - int'(rel_o[d]);
    endtask

    task automatic leak_check();
        int bad;
        bad = 0;
        for (int d = 0; d < ND; d++) if (res[d] != 0) bad++;
        chk(bad == 0, "R10", "directions with leaked lanes", bad, 0);
        for (int d = 0; d < ND; d++) res[d] = 0;
    endtask

    task automatic run_txn(input int dx, input int dy, input int free, input int gm, input int stag);
        int c0, c1, cand, avail, win, gbits, first, rest;
        bit v0, v1, g0, g1;
        string tg;
        v0 = 0; v1 = 0; c0 = 0; c1 = 0;
        if (dx != MX) begin
            v0 = 1; c0 = (dx > MX) ? 0 : 1;
            v1 = (dy != MY); c1 = (dy > MY) ? 2 : 3;
        end else begin
            v0 = (dy != MY); c0 = (dy > MY) ? 2 : 3;
        end
        cand  = (v0 ? (1 << c0) : 0) | (v1 ? (1 << c1) : 0);
        avail = cand & free;
        g0 = v0 && avail[c0] && gm[0];
        g1 = v1 && avail[c1] && gm[1];
        gbits = (g0 ? (1 << c0) : 0) | (g1 ? (1 << c1) : 0);
        if (g0 && g1) begin
            tg = "R6";
            if (bv[c0] < bv[c1]) win = c0;
            else if (bv[c0] == bv[c1]) win = (c0 < c1) ? c0 : c1;
            else win = c1;
        end else begin
            tg = "R7";
            win = g0 ? c0 : (g1 ? c1 : -1);
        end
        for (int d = 0; d < ND; d++) busy_i[d*BW +: BW] = BW'(bv[d]);

        next_cyc();
        req_i = 1'b1; dst_x_i = CW'(dx); dst_y_i = CW'(dy); lane_free_i = ND'(free);
        acct();
        next_cyc();
        req_i = 1'b0;
        acct();
        chk(int'(claim_o) == avail, "R2", "claim mask in route cycle", int'(claim_o), avail);
        if (avail == 0) begin
            chk(up_dny_o == 1'b1, "R3", "immediate deny", int'(up_dny_o), 1);
            next_cyc(); acct();
            chk(down_req_o == '0, "R3", "no forwarded request", int'(down_req_o), 0);
            leak_check();
            return;
        end
        chk(!up_dny_o && !up_gnt_o, "R2", "no reply in route cycle", int'(up_dny_o), 0);

        next_cyc();
        chk(int'(down_req_o) == avail, "R4", "forwarded request mask", int'(down_req_o), avail);
        if (stag != 0 && $countones(ND'(avail)) == 2) begin
            first = 1 << c0;
            down_gnt_i = ND'(first & gbits); down_dny_i = ND'(first & ~gbits);
            acct();
            chk(!up_gnt_o && !up_dny_o, "R4", "no upstream reply while waiting", int'(up_gnt_o), 0);
            next_cyc();
            rest = avail & ~first;
            down_gnt_i = ND'(rest & gbits); down_dny_i = ND'(rest & ~gbits);
            acct();
            chk(int'(down_req_o) == rest, "R4", "pending request mask", int'(down_req_o), rest);
            chk(!up_gnt_o && !up_dny_o, "R4", "no upstream reply before last", int'(up_dny_o), 0);
        end else begin
            down_gnt_i = ND'(avail & gbits); down_dny_i = ND'(avail & ~gbits);
            acct();
        end

        next_cyc();
        down_gnt_i = '0; down_dny_i = '0;
        acct();
        if (win < 0) begin
            chk(up_dny_o && !up_gnt_o, "R5", "deny after all denied", int'(up_dny_o), 1);
            chk(int'(rel_o) == avail, "R5", "release all claimed", int'(rel_o), avail);
            next_cyc(); acct();
            leak_check();
            return;
        end
        chk(up_gnt_o && !up_dny_o, tg, "upstream grant", int'(up_gnt_o), 1);
        chk(int'(rel_o) == (avail & ~(1 << win)), tg, "loser release", int'(rel_o), avail & ~(1 << win));

        next_cyc(); acct();
        chk(chan_active_o == 1'b1, "R8", "transfer active", int'(chan_active_o), 1);
        chk(int'(sel_dir_o) == win, tg, "selected direction", int'(sel_dir_o), win);
        next_cyc();
        req_i = 1'b1; dst_x_i = CW'(4 - dx); dst_y_i = CW'(4 - dy); lane_free_i = '1;
        acct();
        chk(claim_o == '0 && chan_active_o, "R9", "request ignored in transfer", int'(claim_o), 0);
        next_cyc(); acct();
        chk(claim_o == '0 && chan_active_o, "R9", "still in transfer", int'(chan_active_o), 1);
        next_cyc();
        req_i = 1'b0; xfer_done_i = 1'b1;
        acct();
        chk(chan_active_o == 1'b1, "R8", "active until done", int'(chan_active_o), 1);
        next_cyc();
        xfer_done_i = 1'b0;
        acct();
        chk(int'(rel_o) == (1 << win), "R8", "teardown release", int'(rel_o), 1 << win);
        chk(chan_active_o == 1'b0, "R8", "inactive in release", int'(chan_active_o), 0);
        next_cyc(); acct();
        chk(claim_o == '0 && !up_dny_o, "R9", "stale request not taken", int'(claim_o), 0);
        leak_check();
    endtask

    initial begin : watchdog
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        for (int d = 0; d < ND; d++) begin res[d] = 0; bv[d] = 0; end
        repeat (3) @(negedge clk);
        #2;
        chk(claim_o == '0 && rel_o == '0 && down_req_o == '0, "R2", "reset outputs idle", int'(claim_o), 0);
        chk(!up_gnt_o && !up_dny_o && !chan_active_o, "R8", "reset no reply/active", int'(chan_active_o), 0);
        rst_n = 1'b1;
        for (int dx = 0; dx < 5; dx++)
            for (int dy = 0; dy < 5; dy++)
                for (int fr = 0; fr < 16; fr++)
                    for (int gm = 0; gm < 4; gm++) begin
                        for (int d = 0; d < ND; d++) begin
                            if ((dx + dy + fr + gm) % 3 == 0) bv[d] = 3;
                            else bv[d] = (dx * 3 + dy * 5 + d * (fr + 1) + gm) % 8;
                        end
                        run_txn(dx, dy, fr, gm, (gm + dy + fr) % 2);
                    end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule